// File: doc/BRIEF.md
# Shared Buffer Load-Lock Arbiter

This block hands a single exclusive token, the load-lock, to one of several DMA channel threads that share a 512-entry data buffer. A channel that wants to execute a load raises its load request. If that channel already holds the lock, or the lock is free and the channel wins arbitration, the load proceeds in the same cycle. Any other requester is told to pause and keeps its request up until it becomes the owner. When the lock is free and several channels ask at once, the winner is chosen in round-robin order, starting with the channel after the previous owner.

The owner gives the lock back by pulsing its release input. The lock then reads as free from the next cycle on. Alongside the token logic, a capacity monitor adds up the buffer requirement of every running channel. It raises a flag when the combined figure exceeds the buffer depth, because that loading of the buffer can lock up the shared datapath.

Top module: `llk_load_lock`

## Requirements
- R1: While `rst_n` is low at a clock edge, the lock is cleared and `cap_over` goes to 0. After reset the round-robin pointer sits on the last channel, so channel 0 has first priority.
- R2: `lock_owner` is one-hot or all zero in every cycle, so the lock is always free or held by exactly one channel.
- R3: When the lock is free and exactly one channel requests, that channel's `grant` bit is 1 in the same cycle and `lock_owner` shows that channel from the next cycle.
- R4: While the lock is held, a request from any channel other than the owner gives `pause`=1 and `grant`=0 for that channel, and ownership does not change.
- R5: When the lock is free and several channels request together, the grant goes to the first requester found when scanning upward, with wrap-around, from the channel after the most recent owner.
- R6: A `rel` pulse from the owner makes `lock_owner` all zero from the next cycle. In the release cycle itself the lock still counts as held, so other requesters pause.
- R7: A `rel` bit from a channel that does not own the lock has no effect on `lock_owner`.
- R8: An owner that issues further loads gets `grant`=1 and `pause`=0 each time, including in the cycle it releases.
- R9: One cycle after its inputs are presented, `cap_over` is 1 exactly when the sum of `ch_need` over the channels with `ch_active`=1 is greater than 512. A sum of exactly 512 is not flagged, and the needs of inactive channels are ignored.
- R10: For every channel, `grant` and `pause` are never both 1, and their OR equals that channel's `ld_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_req | input | NUM_CH | Channel is executing a load this cycle |
| rel | input | NUM_CH | Release pulse; only the owner's bit has an effect |
| ch_active | input | NUM_CH | Channel is currently running |
| ch_need | input | NUM_CH*NEED_W | Buffer requirement per channel; channel i occupies bits [i*NEED_W +: NEED_W] |
| grant | output | NUM_CH | Load proceeds this cycle |
| pause | output | NUM_CH | Load must stall this cycle |
| lock_owner | output | NUM_CH | One-hot current owner, zero when free |
| cap_over | output | 1 | Registered flag: active requirement exceeds the buffer depth |

## Verification
The bench aims at the cases a careless arbiter gets wrong. It drives simultaneous requests right after different owners, and a pointer that failed to advance or wrap would hand the lock to the same low channel every time. It releases while others are waiting, where a lock freed one cycle early would grant a second channel and break exclusivity. It issues releases from non-owners, which a loose mask would obey. On the capacity side it uses a sum of exactly 512 and one of 513 to expose an off-by-one comparison, and it gives a large need to an inactive channel to catch a monitor that forgets the activity mask.

// File: rtl/llk_pkg.sv
// Package: shared constants and helpers for the load-lock arbiter.
// Assumes: the channel count is at least 2.
package llk_pkg;

    // Depth of the shared data buffer guarded by the lock.
    localparam int unsigned LLK_BUF_ENTRIES = 512;

    // Index width for a given channel count (at least 1 bit).
    function automatic int unsigned llk_idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/llk_rr_pick.sv
// Module: round-robin picker.
// Chooses one requester, scanning upward from the channel after `last_idx`
// and wrapping around. Purely combinational.
// Assumes: last_idx < NUM_CH.
module llk_rr_pick #(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned IW = llk_pkg::llk_idx_w(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [IW-1:0]     last_idx,
    output logic [NUM_CH-1:0] pick,
    output logic [IW-1:0]     pick_idx,
    output logic              pick_vld
);

    // Scan requesters in rotated priority order; the first hit wins.
    always_comb begin
        int k;
        pick     = '0;
        pick_idx = last_idx;
        pick_vld = 1'b0;
        for (int off = 1; off <= int'(NUM_CH); off++) begin
            k = (int'(last_idx) + off) % int'(NUM_CH);
            if (!pick_vld && req[k]) begin
                pick_vld = 1'b1;
                pick[k]  = 1'b1;
                pick_idx = IW'(k);
            end
        end
    end

endmodule

// File: rtl/llk_lock_state.sv
// Module: lock ownership register.
// Holds the one-hot owner and the index of the most recent owner. A free
// lock is claimed by the offered winner. An owner release frees the lock
// on the next edge. Releases from non-owners are masked off.
// Assumes: claim_pick is one-hot or zero and matches claim_idx.
module llk_lock_state #(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned IW = llk_pkg::llk_idx_w(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] claim_pick,
    input  logic [IW-1:0]     claim_idx,
    input  logic              claim_vld,
    input  logic [NUM_CH-1:0] rel,
    output logic [NUM_CH-1:0] owner_q,
    output logic [IW-1:0]     last_q
);

    logic held;
    logic owner_rel;

    // Decode whether the lock is held and whether its owner lets go.
    always_comb begin
        held      = |owner_q;
        owner_rel = |(rel & owner_q);
    end

    // Update ownership: release first when held, otherwise accept a claim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            last_q  <= IW'(NUM_CH - 1);
        end else if (held) begin
            if (owner_rel) begin
                owner_q <= '0;
            end
        end else if (claim_vld) begin
            owner_q <= claim_pick;
            last_q  <= claim_idx;
        end
    end

    p_single_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owner_q));

    p_claim_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && claim_vld) |=> (owner_q == $past(claim_pick)));

    p_release_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (held && owner_rel) |=> (owner_q == '0));

    p_foreign_rel_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !owner_rel) |=> $stable(owner_q));

endmodule

// File: rtl/llk_cap_check.sv
// Module: buffer capacity monitor.
// Adds up the requirement of the running channels and registers a flag
// when the total exceeds the buffer depth.
// Assumes: need values are unsigned.
module llk_cap_check #(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned NEED_W    = 10,
    parameter int unsigned BUF_DEPTH = llk_pkg::LLK_BUF_ENTRIES,
    localparam int unsigned SUM_W = NEED_W + llk_pkg::llk_idx_w(NUM_CH) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        ch_active,
    input  logic [NUM_CH*NEED_W-1:0] ch_need,
    output logic                     cap_over
);

    logic [NUM_CH-1:0][SUM_W-1:0] masked;
    logic [SUM_W-1:0]             total;

    // Per channel: zero-extend the need and drop it if the channel is idle.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
        always_comb begin
            masked[c] = ch_active[c] ? SUM_W'(ch_need[c*NEED_W +: NEED_W]) : '0;
        end
    end

    // Accumulate the masked requirements.
    always_comb begin
        total = '0;
        for (int c = 0; c < int'(NUM_CH); c++) begin
            total = total + masked[c];
        end
    end

    // Register the comparison against the buffer depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_over <= 1'b0;
        end else begin
            cap_over <= (total > SUM_W'(BUF_DEPTH));
        end
    end

    p_idle_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_active == '0) |=> !cap_over);

endmodule

// File: rtl/llk_load_lock.sv
// Module: load-lock arbiter top.
// The lock owner proceeds on every load. When the lock is free, the
// round-robin winner among the requesters proceeds and becomes the owner.
// Every other requester pauses. A capacity monitor runs beside the arbiter.
// Assumes: a paused channel holds ld_req until it is granted.
module llk_load_lock #(
    parameter int unsigned NUM_CH    = 4,
    parameter int unsigned NEED_W    = 10,
    parameter int unsigned BUF_DEPTH = llk_pkg::LLK_BUF_ENTRIES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        ld_req,
    input  logic [NUM_CH-1:0]        rel,
    input  logic [NUM_CH-1:0]        ch_active,
    input  logic [NUM_CH*NEED_W-1:0] ch_need,
    output logic [NUM_CH-1:0]        grant,
    output logic [NUM_CH-1:0]        pause,
    output logic [NUM_CH-1:0]        lock_owner,
    output logic                     cap_over
);

    localparam int unsigned IW = llk_pkg::llk_idx_w(NUM_CH);

    logic [NUM_CH-1:0] pick;
    logic [IW-1:0]     pick_idx;
    logic              pick_vld;
    logic [IW-1:0]     last_idx;
    logic              lock_free;

    llk_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
        .req      (ld_req),
        .last_idx (last_idx),
        .pick     (pick),
        .pick_idx (pick_idx),
        .pick_vld (pick_vld)
    );

    llk_lock_state #(.NUM_CH(NUM_CH)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .claim_pick (pick),
        .claim_idx  (pick_idx),
        .claim_vld  (pick_vld),
        .rel        (rel),
        .owner_q    (lock_owner),
        .last_q     (last_idx)
    );

    llk_cap_check #(
        .NUM_CH    (NUM_CH),
        .NEED_W    (NEED_W),
        .BUF_DEPTH (BUF_DEPTH)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_active (ch_active),
        .ch_need   (ch_need),
        .cap_over  (cap_over)
    );

    // Grant the owner, or the round-robin winner on a free lock; pause the rest.
    always_comb begin
        lock_free = (lock_owner == '0);
        grant     = ld_req & (lock_free ? pick : lock_owner);
        pause     = ld_req & ~grant;
    end

    p_grant_pause_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & pause) == '0) && ((grant | pause) == ld_req));

    p_nonowner_pauses_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_free) |-> ((grant & ~lock_owner) == '0));

    p_owner_proceeds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ld_req & lock_owner) != '0) |-> ((pause & lock_owner) == '0));

    p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

endmodule

// File: tb/tb_llk_load_lock.sv
`timescale 1ns/1ps
module tb_llk_load_lock;

    localparam int N  = 4;
    localparam int NW = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    ld_req, rel, ch_active;
    logic [N*NW-1:0] ch_need;
    logic [N-1:0]    grant, pause, lock_owner;
    logic            cap_over;

    llk_load_lock #(.NUM_CH(N), .NEED_W(NW), .BUF_DEPTH(512)) dut (
        .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .rel(rel),
        .ch_active(ch_active), .ch_need(ch_need), .grant(grant),
        .pause(pause), .lock_owner(lock_owner), .cap_over(cap_over)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [N-1:0] g;
        logic [N-1:0] p;
        logic [N-1:0] o;
        logic         c;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   m_owner = -1;
    int   m_last  = N - 1;
    bit   done    = 0;

    task automatic chk(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    function automatic logic [N*NW-1:0] mk_need(input int a, input int b, input int c, input int d);
        return {NW'(d), NW'(c), NW'(b), NW'(a)};
    endfunction

    // Driver: apply one cycle of stimulus and push the modelled expectation.
    task automatic step(input logic [N-1:0] ld, input logic [N-1:0] rl,
                        input logic [N-1:0] ac, input logic [N*NW-1:0] nd,
                        input string tag);
        exp_t e;
        int   nxt;
        int   win;
        int   sum;
        @(negedge clk);
        ld_req = ld; rel = rl; ch_active = ac; ch_need = nd;
        e.g = '0;
        if (m_owner >= 0) begin
            e.g = ld & (N'(1) << m_owner);
            nxt = rl[m_owner] ? -1 : m_owner;
        end else begin
            win = -1;
            for (int off = 1; off <= N; off++) begin
                int k;
                k = (m_last + off) % N;
                if (win < 0 && ld[k]) win = k;
            end
            if (win >= 0) begin
                e.g = N'(1) << win;
                m_last = win;
            end
            nxt = win;
        end
        e.p = ld & ~e.g;
        e.o = (nxt >= 0) ? (N'(1) << nxt) : '0;
        sum = 0;
        for (int c = 0; c < N; c++) if (ac[c]) sum += int'(nd[c*NW +: NW]);
        e.c = (sum > 512);
        e.tag = tag;
        m_owner = nxt;
        q.push_back(e);
    endtask

    // Monitor: pop each expectation and compare both phases of that cycle.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(e.tag, "grant", grant, e.g);
                chk(e.tag, "pause", pause, e.p);
                chk("R10", "grant&pause", grant & pause, '0);
                @(posedge clk);
                #1;
                chk(e.tag, "lock_owner", lock_owner, e.o);
                chk(e.tag, "cap_over", N'(cap_over), N'(e.c));
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
    end

    initial begin
        logic [N*NW-1:0] z;
        z = '0;
        rst_n = 1'b0; ld_req = '0; rel = '0;
        ch_active = '1; ch_need = '1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "lock_owner reset", lock_owner, '0);
        chk("R1", "cap_over reset", N'(cap_over), '0);
        ch_active = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R3 single claim; R8 owner reloads; R4 others pause
        step(4'b0100, 4'b0000, 4'b0000, z, "R3");
        step(4'b0111, 4'b0000, 4'b0000, z, "R4/R8");
        step(4'b0011, 4'b0010, 4'b0000, z, "R7");
        step(4'b0101, 4'b0100, 4'b0000, z, "R6");
        // R5: free, after owner 2 -> channel 3 first
        step(4'b1011, 4'b0000, 4'b0000, z, "R5");
        step(4'b0011, 4'b1000, 4'b0000, z, "R6");
        // R5: after owner 3 -> wrap to channel 0
        step(4'b1111, 4'b0000, 4'b0000, z, "R5");
        step(4'b0000, 4'b0001, 4'b0000, z, "R6");
        step(4'b0110, 4'b0000, 4'b0000, z, "R5");
        step(4'b0000, 4'b1101, 4'b0000, z, "R7");
        step(4'b0000, 4'b0010, 4'b0000, z, "R6");
        step(4'b0000, 4'b1111, 4'b0000, z, "R7");

        // R9 capacity boundaries
        step(4'b0000, 4'b0000, 4'b1111, mk_need(128, 128, 128, 128), "R9");
        step(4'b0000, 4'b0000, 4'b1111, mk_need(129, 128, 128, 128), "R9");
        step(4'b0000, 4'b0000, 4'b0111, mk_need(128, 128, 128, 1000), "R9");
        step(4'b0000, 4'b0000, 4'b1000, mk_need(1023, 1023, 1023, 513), "R9");

        // Mixed traffic
        for (int i = 0; i < 80; i++) begin
            step(N'($urandom), N'($urandom) & N'($urandom),
                 N'($urandom), mk_need($urandom % 256, $urandom % 256,
                                       $urandom % 256, $urandom % 256), "R5/R9");
        end
        step('0, '0, '0, z, "R2");
        repeat (3) @(negedge clk);
        report();
    end

endmodule